// File: doc/BRIEF.md
# Multiplexed Video-Memory Bus Controller

This block turns video-memory read and write requests from the rest of the chip into cycles on an external memory bus. The address is 14 bits wide. Its upper six bits leave on dedicated outputs. Its low byte shares eight pins with the data. The shared pins are presented as separate output, output-enable and input vectors, so that the pad ring outside the block can build the tristate buffers.

Each access takes two bus cycles. In the address cycle, a latch-enable pulse lets an external latch capture the low address byte while that byte is on the shared pins. In the data cycle, an active-low read or write strobe is driven.

Writes to the upper page 0x3F00..0x3FFF target the on-chip palette. They still show the address cycle on the bus. The data goes to an internal palette write port instead, and the external write strobe stays inactive. The client side uses a simple handshake: `idle` shows when a request can be taken, and `done` pulses once per completed access, with read data valid alongside it.

Top module: `vbus_ctrl`

## Requirements
- R1: After reset, `ale` is 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0, `pal_we` is 0, `done` is 0, `idle` is 1 and `addr_hi` is 0.
- R2: A request (`req`=1) is taken only at a clock edge where `idle` is 1. While an access is in progress, `req` is ignored: no extra latch-enable pulse appears.
- R3: In the cycle after a request is taken, the following hold:
  - `ale` is 1 for exactly that one cycle.
  - `ad_out` carries address bits 7:0 with `ad_oe` set.
  - `addr_hi` carries address bits 13:8.
  - Both strobes are inactive (1).
- R4: For a write outside the palette page, the cycle after the address cycle has `wr_n`=0, `rd_n`=1, `ale`=0, `ad_oe`=1 and `ad_out` equal to the write data.
- R5: For a read, at any address, the cycle after the address cycle has `rd_n`=0, `wr_n`=1 and `ad_oe`=0. The value on `ad_in` at the end of that cycle is captured.
- R6: `done` is 1 for exactly the one cycle after the data cycle. On a read, `rdata` equals the captured byte while `done` is 1, and it holds until the next read completes.
- R7: A write whose address bits 13:8 equal 0x3F has these properties:
  - It never drives `wr_n` low.
  - It does not drive the shared pins in its data cycle.
  - In its data cycle it raises `pal_we`, with `pal_addr` equal to address bits 7:0 and `pal_wdata` equal to the write data.
  - Its `done` timing is the same as an external access.
- R8: `pal_we` stays 0 for all reads and for writes outside the palette page.
- R9: `ad_oe` is 1 only in an address cycle or in the data cycle of an external write.
- R10: A request presented in the cycle where `done` is 1 is taken at once, so its latch-enable pulse follows in the next cycle.
- R11: `rd_n` and `wr_n` are never both 0, and neither is 0 while `ale` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Video-memory address |
| req_wdata | input | 8 | Write data |
| idle | output | 1 | Controller can take a request this cycle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last read byte, valid with `done` |
| ale | output | 1 | Address latch enable |
| ad_out | output | 8 | Shared pins, outgoing value |
| ad_oe | output | 1 | Shared pins, drive enable |
| ad_in | input | 8 | Shared pins, incoming value |
| addr_hi | output | 6 | Address bits 13:8 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| pal_we | output | 1 | Palette write enable |
| pal_addr | output | 8 | Palette write address (low byte) |
| pal_wdata | output | 8 | Palette write data |

## Verification
The completion pulse of one access and the acceptance of the next request can fall in the same cycle. The bench provokes this by raising a fresh request exactly in the `done` cycle. It judges the result by requiring `done` and `rdata` to reflect the old access in that cycle, then a latch-enable pulse with the new address in the following cycle. The opposite case is checked as well: a request held high during the address and data cycles must not produce a second pulse.

// File: rtl/vbus_pkg.sv
package vbus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } vbus_phase_e;

  function automatic logic is_busy(input vbus_phase_e ph);
    return ph != PH_IDLE;
  endfunction
endpackage

// File: rtl/vbus_fsm.sv
module vbus_fsm
  import vbus_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 8,
  parameter int LO_W    = 8,
  parameter int PAL_TAG = 'h3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bus_in_i,
  output vbus_phase_e       phase_o,
  output logic              accept_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic              we_q_o,
  output logic              pal_q_o,
  output logic [DATA_W-1:0] wdata_q_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HI_W = ADDR_W - LO_W;

  function automatic logic hits_palette(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LO_W] == HI_W'(PAL_TAG);
  endfunction

  vbus_phase_e phase_q;

  assign accept_o = req_i && (phase_q == PH_IDLE);
  assign phase_o  = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      addr_q_o  <= '0;
      we_q_o    <= 1'b0;
      pal_q_o   <= 1'b0;
      wdata_q_o <= '0;
      done_o    <= 1'b0;
      rdata_o   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (accept_o) begin
          phase_q   <= PH_ADDR;
          addr_q_o  <= addr_i;
          we_q_o    <= we_i;
          pal_q_o   <= we_i && hits_palette(addr_i);
          wdata_q_o <= wdata_i;
        end
        PH_ADDR: phase_q <= PH_DATA;
        PH_DATA: begin
          phase_q <= PH_IDLE;
          done_o  <= 1'b1;
          if (!we_q_o) rdata_o <= bus_in_i;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA) |=> done_o); // R6
endmodule

// File: rtl/vbus_pindrv.sv
module vbus_pindrv
  import vbus_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8,
  parameter int LO_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  vbus_phase_e          phase_i,
  input  logic [ADDR_W-1:0]    addr_q_i,
  input  logic                 we_q_i,
  input  logic                 pal_q_i,
  input  logic [DATA_W-1:0]    wdata_q_i,
  output logic                 ale_o,
  output logic [DATA_W-1:0]    ad_out_o,
  output logic                 ad_oe_o,
  output logic [ADDR_W-LO_W-1:0] addr_hi_o,
  output logic                 rd_n_o,
  output logic                 wr_n_o,
  output logic                 pal_we_o,
  output logic [LO_W-1:0]      pal_addr_o,
  output logic [DATA_W-1:0]    pal_wdata_o
);
  logic in_addr, in_data, ext_wr;

  assign in_addr = (phase_i == PH_ADDR);
  assign in_data = (phase_i == PH_DATA);
  assign ext_wr  = in_data && we_q_i && !pal_q_i;

  assign ale_o       = in_addr;
  assign rd_n_o      = !(in_data && !we_q_i);
  assign wr_n_o      = !ext_wr;
  assign ad_oe_o     = in_addr || ext_wr;
  assign ad_out_o    = in_addr ? DATA_W'(addr_q_i[LO_W-1:0]) : wdata_q_i;
  assign addr_hi_o   = addr_q_i[ADDR_W-1:LO_W];
  assign pal_we_o    = in_data && pal_q_i;
  assign pal_addr_o  = addr_q_i[LO_W-1:0];
  assign pal_wdata_o = wdata_q_i;

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !ale_o); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o)); // R11
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (rd_n_o && wr_n_o)); // R11
  AST_PAL_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we_o |-> (wr_n_o && !ad_oe_o)); // R7
endmodule

// File: rtl/vbus_ctrl.sv
module vbus_ctrl
  import vbus_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 8,
  parameter int LO_W    = 8,
  parameter int PAL_TAG = 'h3F
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   req_we,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   idle,
  output logic                   done,
  output logic [DATA_W-1:0]      rdata,
  output logic                   ale,
  output logic [DATA_W-1:0]      ad_out,
  output logic                   ad_oe,
  input  logic [DATA_W-1:0]      ad_in,
  output logic [ADDR_W-LO_W-1:0] addr_hi,
  output logic                   rd_n,
  output logic                   wr_n,
  output logic                   pal_we,
  output logic [LO_W-1:0]        pal_addr,
  output logic [DATA_W-1:0]      pal_wdata
);
  vbus_phase_e       phase;
  logic              accept, we_q, pal_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign idle = !is_busy(phase);

  vbus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO_W(LO_W), .PAL_TAG(PAL_TAG)) fsm_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(req_we), .addr_i(req_addr),
    .wdata_i(req_wdata), .bus_in_i(ad_in), .phase_o(phase), .accept_o(accept),
    .addr_q_o(addr_q), .we_q_o(we_q), .pal_q_o(pal_q), .wdata_q_o(wdata_q),
    .done_o(done), .rdata_o(rdata)
  );

  vbus_pindrv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO_W(LO_W)) pins_i (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .addr_q_i(addr_q), .we_q_i(we_q),
    .pal_q_i(pal_q), .wdata_q_i(wdata_q), .ale_o(ale), .ad_out_o(ad_out),
    .ad_oe_o(ad_oe), .addr_hi_o(addr_hi), .rd_n_o(rd_n), .wr_n_o(wr_n),
    .pal_we_o(pal_we), .pal_addr_o(pal_addr), .pal_wdata_o(pal_wdata)
  );

  AST_ACCEPT_TO_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    (req && idle) |=> ale); // R2
  AST_BUSY_NO_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> !ale || $past(ale) == 1'b0); // R2
  AST_OE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (ale || !wr_n)); // R9
  AST_PALWE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |-> rd_n); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle); // R10
endmodule

// File: tb/vbus_ctrl_tb_top.sv
module vbus_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [13:0] req_addr = '0;
  logic [7:0] req_wdata = '0, ad_in = '0;
  logic idle, done, ale, ad_oe, rd_n, wr_n, pal_we;
  logic [7:0] rdata, ad_out, pal_addr, pal_wdata;
  logic [5:0] addr_hi;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  vbus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .idle(idle), .done(done), .rdata(rdata), .ale(ale),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi), .rd_n(rd_n),
    .wr_n(wr_n), .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  function automatic bit is_pal(input logic [13:0] a);
    return a >= 14'h3F00;
  endfunction

  // Presents a request at a negedge; the accepting edge is the next posedge.
  task automatic present(input bit we, input logic [13:0] a, input logic [7:0] d);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
  endtask

  // Called at the negedge inside the address cycle; checks the address and data phases.
  task automatic addr_and_data(input bit we, input logic [13:0] a, input logic [7:0] d,
                               input logic [7:0] bus_val);
    eq("R3 ale", ale, 1);
    eq("R3 ad_oe", ad_oe, 1);
    eq("R3 ad_out", ad_out, a[7:0]);
    eq("R3 addr_hi", addr_hi, a[13:8]);
    eq("R11 strobes in addr", {rd_n, wr_n}, 2'b11);
    ad_in = bus_val;
    @(negedge clk);
    eq("R3 ale single", ale, 0);
    eq("R3 addr_hi held", addr_hi, a[13:8]);
    if (!we) begin
      eq("R5 rd_n", rd_n, 0);
      eq("R5 wr_n", wr_n, 1);
      eq("R5 released", ad_oe, 0);
      eq("R8 pal_we read", pal_we, 0);
    end else if (is_pal(a)) begin
      eq("R7 wr_n", wr_n, 1);
      eq("R7 rd_n", rd_n, 1);
      eq("R7 ad_oe", ad_oe, 0);
      eq("R7 pal_we", pal_we, 1);
      eq("R7 pal_addr", pal_addr, a[7:0]);
      eq("R7 pal_wdata", pal_wdata, d);
    end else begin
      eq("R4 wr_n", wr_n, 0);
      eq("R4 rd_n", rd_n, 1);
      eq("R4 ad_oe", ad_oe, 1);
      eq("R4 ad_out", ad_out, d);
      eq("R8 pal_we ext", pal_we, 0);
    end
    eq("R6 done early", done, 0);
  endtask

  task automatic single_access(input bit we, input logic [13:0] a, input logic [7:0] d,
                               input logic [7:0] bus_val, input logic [7:0] exp_rd);
    @(negedge clk);
    eq("R2 idle before", idle, 1);
    present(we, a, d);
    @(negedge clk);
    req = 1'b0;
    addr_and_data(we, a, d, bus_val);
    @(negedge clk);
    eq("R6 done", done, 1);
    eq("R9 oe in done", ad_oe, 0);
    eq("R6 rdata", rdata, exp_rd);
    eq("R11 strobes idle", {rd_n, wr_n}, 2'b11);
    @(negedge clk);
    eq("R6 done one cycle", done, 0);
    eq("R6 rdata held", rdata, exp_rd);
    eq("R2 no ale without req", ale, 0);
  endtask

  task automatic test_reset();
    eq("R1 ale", ale, 0);
    eq("R1 strobes", {rd_n, wr_n}, 2'b11);
    eq("R1 ad_oe", ad_oe, 0);
    eq("R1 pal_we", pal_we, 0);
    eq("R1 done", done, 0);
    eq("R1 idle", idle, 1);
    eq("R1 addr_hi", addr_hi, 0);
  endtask

  task automatic test_busy_ignored();
    @(negedge clk);
    present(1'b1, 14'h0123, 8'h5A);
    @(negedge clk);
    req_addr = 14'h2BCD;  // R2: new request while busy must be ignored
    req_wdata = 8'hEE;
    eq("R2 idle busy", idle, 0);
    addr_and_data(1'b1, 14'h0123, 8'h5A, 8'h00);
    req = 1'b0;
    @(negedge clk);
    eq("R6 done busy test", done, 1);
    @(negedge clk);
    eq("R2 no extra ale", ale, 0);
    eq("R2 idle after", idle, 1);
  endtask

  task automatic test_back_to_back();
    logic [7:0] last_rd;
    @(negedge clk);
    present(1'b0, 14'h1E07, 8'h00);
    @(negedge clk);
    req = 1'b0;
    addr_and_data(1'b0, 14'h1E07, 8'h00, 8'hC3);
    @(negedge clk);
    eq("R10 done", done, 1);
    eq("R10 rdata", rdata, 8'hC3);
    eq("R10 idle in done", idle, 1);
    present(1'b1, 14'h3F1C, 8'h2D);  // R10 request in the done cycle
    @(negedge clk);
    req = 1'b0;
    eq("R10 done dropped", done, 0);
    addr_and_data(1'b1, 14'h3F1C, 8'h2D, 8'h00);
    @(negedge clk);
    eq("R7 done palette", done, 1);
    last_rd = rdata;
    eq("R6 rdata kept on write", last_rd, 8'hC3);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    single_access(1'b1, 14'h2A55, 8'h96, 8'h00, 8'h00);   // R4 external write
    single_access(1'b0, 14'h0F80, 8'h00, 8'h3C, 8'h3C);   // R5 read
    single_access(1'b1, 14'h3F00, 8'h11, 8'h00, 8'h3C);   // R7 palette low edge
    single_access(1'b1, 14'h3FFF, 8'h22, 8'h00, 8'h3C);   // R7 palette top edge
    single_access(1'b1, 14'h3EFF, 8'h33, 8'h00, 8'h3C);   // R4 just below palette
    single_access(1'b0, 14'h3F10, 8'h00, 8'hA7, 8'hA7);   // R8 palette-page read goes out
    test_busy_ignored();
    test_back_to_back();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule